// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Transmitter

This block is the transmit half of a bulk IN endpoint in a full-speed USB device. Software loads data bytes one at a time into a pair of packet buffers. A buffer is committed for transmission in one of two ways: the buffer reaches its full packet size, or software sets a short-packet bit in the control/status register. The serial engine presents IN tokens. For each token the block answers in one of two ways: it announces a data packet and streams the bytes of the oldest committed buffer, or it answers NAK. The serial engine then reports whether the host acknowledged the packet or the transfer timed out.

Status bits in one register cover buffer service, packet completion, flush and underrun. The interrupt-source output follows the completion bit, gated by an enable input. The byte stream toward the serial engine uses valid/ready. `tx_valid` and `tx_data` hold steady until `tx_ready` is high on a clock edge. The engine may hold `tx_ready` low for any number of cycles. Processor writes are plain strobes with no back-pressure. A byte written while both buffers are committed is dropped, and a sticky overflow flag is raised.

Top module: `bulk_in_ep`

## Requirements
- R1: When a buffer holds PKT_BYTES loaded bytes, it becomes committed and byte loading moves to the other buffer.
- R2: Writing 1 to control bit 4 (short commit) commits the buffer being filled, whatever its byte count. A buffer committed with zero bytes is sent as a data packet of length 0. Bit 4 reads 0.
- R3: Bit 0 (service) reads 1 while at most one buffer is committed and 0 while both are committed.
- R4: Bit 1 (done) is set when the host acknowledges a packet. Writing 1 to bit 1 clears it. If an acknowledge and a clear arrive in the same cycle, the acknowledge wins.
- R5: `irq` is high exactly when done is set and `irq_en` is high.
- R6: An IN token gets `resp_data` with the packet length when a committed buffer exists, even while done is set. It gets `resp_nak` when no buffer is committed.
- R7: Writing 1 to bit 2, or pulsing `cfg_evt`, discards both buffers and any partial fill. Bit 2 reads 0.
- R8: An IN token that finds no committed buffer while done is clear sets bit 3 (underrun) and is NAKed. Underrun never raises `irq` and is cleared by writing 1 to bit 3.
- R9: Committed buffers are sent oldest first, in the order in which they were committed.
- R10: After `host_timeout`, the packet stays committed and is sent again, byte for byte, on the next IN token. Only `host_ack` frees the buffer.
- R11: A data byte written while both buffers are committed is dropped, and `ovf` sets and stays set until reset.
- R12: The stream holds each byte until accepted, delivers exactly the packet length in bytes, and raises `tx_last` on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_we | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Data byte |
| csr_we | input | 1 | Control/status write strobe |
| csr_wdata | input | 8 | Control/status write value |
| csr_rdata | output | 8 | Control/status read value |
| cfg_evt | input | 1 | Configuration/interface change, flushes the FIFO |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Interrupt source |
| in_tok | input | 1 | IN token pulse from the serial engine |
| resp_data | output | 1 | Pulse: a data packet follows |
| resp_nak | output | 1 | Pulse: answer NAK |
| resp_len | output | LEN_W | Length of the announced packet |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the packet |
| host_ack | input | 1 | Host acknowledged the packet |
| host_timeout | input | 1 | Host did not acknowledge |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with PKT_BYTES = 8. With that size, the random mix of byte writes, short commits, IN transactions, flushes and register clears often fills both buffers. This keeps the double-full service state, overflow drops and back-to-back full-size packets in frequent reach. Zero-length packets and timeout resends are driven directly, and the stream is back-pressured at random.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int CSR_SVC   = 0;
  localparam int CSR_DONE  = 1;
  localparam int CSR_FLUSH = 2;
  localparam int CSR_UND   = 3;
  localparam int CSR_SHORT = 4;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ep_pktbuf.sv
module ep_pktbuf #(
  parameter int PKT_BYTES = 64,
  parameter int LEN_W     = $clog2(PKT_BYTES + 1),
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             commit_req,
  input  logic             release_i,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [LEN_W-1:0] rd_len,
  output logic [7:0]       rd_byte,
  output logic [1:0]       n_committed,
  output logic             ovf
);
  localparam logic [LEN_W-1:0] LAST_CNT = LEN_W'(PKT_BYTES - 1);

  logic             wr_ptr, rd_ptr;
  logic [1:0]       com_w;
  logic [LEN_W-1:0] cnt_w [2];
  logic [7:0]       byte_w [2];
  logic             wr_full, wr_take, fill_commit, short_commit, any_commit;

  assign wr_full      = com_w[wr_ptr];
  assign wr_take      = wr_en && !wr_full && !flush;
  assign fill_commit  = wr_take && (cnt_w[wr_ptr] == LAST_CNT);
  assign short_commit = commit_req && !wr_en && !wr_full && !flush;
  assign any_commit   = fill_commit || short_commit;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [7:0]       mem [PKT_BYTES];
    logic             com_q;
    logic [LEN_W-1:0] cnt_q;
    logic             sel_wr, sel_rd;

    assign sel_wr = (wr_ptr == 1'(g));
    assign sel_rd = (rd_ptr == 1'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        com_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (wr_take && sel_wr) cnt_q <= cnt_q + 1'b1;
        if (any_commit && sel_wr) com_q <= 1'b1;
        if (release_i && sel_rd) begin
          com_q <= 1'b0;
          cnt_q <= '0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (wr_take && sel_wr) mem[cnt_q[IDX_W-1:0]] <= wr_data;
    end

    assign com_w[g]  = com_q;
    assign cnt_w[g]  = cnt_q;
    assign byte_w[g] = mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (wr_en && wr_full && !flush) ovf <= 1'b1;
      if (flush) begin
        wr_ptr <= 1'b0;
        rd_ptr <= 1'b0;
      end else begin
        if (any_commit) wr_ptr <= ~wr_ptr;
        if (release_i)  rd_ptr <= ~rd_ptr;
      end
    end
  end

  assign rd_valid    = com_w[rd_ptr];
  assign rd_len      = cnt_w[rd_ptr];
  assign rd_byte     = byte_w[rd_ptr];
  assign n_committed = 2'(com_w[0]) + 2'(com_w[1]);

  // R11: dropping a byte into a full pair raises the sticky flag
  p_ovf_on_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full && !flush) |=> ovf);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R1: the final byte of a full packet commits the buffer it landed in
  p_fill_commits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit |=> com_w[$past(wr_ptr)]);
  // R9: the read pointer only advances when a buffer is released
  p_rd_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_i && !flush) |=> $stable(rd_ptr));
endmodule

// File: rtl/ep_txsched.sv
module ep_txsched
  import ep_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int LEN_W     = $clog2(PKT_BYTES + 1),
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_tok,
  input  logic             rd_valid,
  input  logic [LEN_W-1:0] rd_len,
  input  logic             done,
  input  logic             tx_ready,
  input  logic             host_ack,
  input  logic             host_timeout,
  output logic             resp_data,
  output logic             resp_nak,
  output logic [LEN_W-1:0] resp_len,
  output logic             tx_valid,
  output logic             tx_last,
  output logic [IDX_W-1:0] rd_idx,
  output logic             release_o,
  output logic             und_set
);
  tx_state_e        state_q;
  logic [LEN_W-1:0] idx_q;
  logic             tok_idle, fire;

  assign tok_idle  = in_tok && (state_q == TX_IDLE) && !flush;
  assign tx_valid  = (state_q == TX_SEND);
  assign tx_last   = tx_valid && (idx_q == resp_len - 1'b1);
  assign fire      = tx_valid && tx_ready;
  assign rd_idx    = idx_q[IDX_W-1:0];
  assign release_o = (state_q == TX_WAIT) && host_ack && !flush;
  assign und_set   = tok_idle && !rd_valid && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      idx_q     <= '0;
      resp_data <= 1'b0;
      resp_nak  <= 1'b0;
      resp_len  <= '0;
    end else begin
      resp_data <= 1'b0;
      resp_nak  <= 1'b0;
      if (flush) begin
        state_q <= TX_IDLE;
        idx_q   <= '0;
      end else begin
        case (state_q)
          TX_IDLE: begin
            if (tok_idle) begin
              if (rd_valid) begin
                resp_data <= 1'b1;
                resp_len  <= rd_len;
                idx_q     <= '0;
                state_q   <= (rd_len == '0) ? TX_WAIT : TX_SEND;
              end else begin
                resp_nak <= 1'b1;
              end
            end
          end
          TX_SEND: begin
            if (fire) begin
              if (tx_last) state_q <= TX_WAIT;
              else         idx_q   <= idx_q + 1'b1;
            end
          end
          TX_WAIT: begin
            if (host_ack || host_timeout) state_q <= TX_IDLE;
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end

  // R6: a token never draws both answers
  p_one_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_data && resp_nak));
  // R12: a non-empty announced packet is followed by stream data
  p_stream_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_data && resp_len != '0) |-> tx_valid);
  // R12: an unaccepted byte is held
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(idx_q)));
endmodule

// File: rtl/ep_csr.sv
module ep_csr
  import ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_we,
  input  logic [7:0] csr_wdata,
  input  logic       pkt_sent,
  input  logic       und_set,
  input  logic [1:0] n_committed,
  input  logic       irq_en,
  output logic [7:0] csr_rdata,
  output logic       irq,
  output logic       done,
  output logic       flush_req,
  output logic       short_req
);
  logic und_q;

  assign flush_req = csr_we && csr_wdata[CSR_FLUSH];
  assign short_req = csr_we && csr_wdata[CSR_SHORT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      und_q <= 1'b0;
    end else begin
      if (pkt_sent)                           done <= 1'b1;
      else if (csr_we && csr_wdata[CSR_DONE]) done <= 1'b0;
      if (und_set)                            und_q <= 1'b1;
      else if (csr_we && csr_wdata[CSR_UND])  und_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[CSR_SVC]  = (n_committed <= 2'd1);
    csr_rdata[CSR_DONE] = done;
    csr_rdata[CSR_UND]  = und_q;
  end

  assign irq = done && irq_en;

  // R4: an acknowledged packet sets done even against a same-cycle clear
  p_done_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |=> done);
  // R8: underrun alone never raises the interrupt
  p_und_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !done) |-> !irq);
  // R8: underrun holds until cleared by software
  p_und_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !(csr_we && csr_wdata[CSR_UND])) |=> und_q);
endmodule

// File: rtl/bulk_in_ep.sv
module bulk_in_ep #(
  parameter int PKT_BYTES = 64,
  parameter int LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  input  logic             csr_we,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic             cfg_evt,
  input  logic             irq_en,
  output logic             irq,
  input  logic             in_tok,
  output logic             resp_data,
  output logic             resp_nak,
  output logic [LEN_W-1:0] resp_len,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             host_ack,
  input  logic             host_timeout,
  output logic             ovf
);
  localparam int IDX_W = $clog2(PKT_BYTES);

  logic             flush, flush_req, short_req, done, release_w, und_set;
  logic             rd_valid;
  logic [LEN_W-1:0] rd_len;
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       n_committed;

  assign flush = flush_req || cfg_evt;

  ep_pktbuf #(.PKT_BYTES(PKT_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(dat_we), .wr_data(dat_wdata), .commit_req(short_req),
    .release_i(release_w), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_len(rd_len), .rd_byte(tx_data),
    .n_committed(n_committed), .ovf(ovf)
  );

  ep_txsched #(.PKT_BYTES(PKT_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_tok(in_tok),
    .rd_valid(rd_valid), .rd_len(rd_len), .done(done),
    .tx_ready(tx_ready), .host_ack(host_ack), .host_timeout(host_timeout),
    .resp_data(resp_data), .resp_nak(resp_nak), .resp_len(resp_len),
    .tx_valid(tx_valid), .tx_last(tx_last), .rd_idx(rd_idx),
    .release_o(release_w), .und_set(und_set)
  );

  ep_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .pkt_sent(release_w), .und_set(und_set), .n_committed(n_committed),
    .irq_en(irq_en), .csr_rdata(csr_rdata), .irq(irq), .done(done),
    .flush_req(flush_req), .short_req(short_req)
  );

  // R7: a flush leaves nothing committed
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (n_committed == 2'd0 && !tx_valid));
  // R6: the data answer only comes for a committed buffer
  p_data_needs_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !tx_valid && !flush && !rd_valid) |=> !resp_data);
endmodule

// File: tb/bulk_in_ep_test.sv
`timescale 1ns/1ps
module bulk_in_ep_test;
  localparam int PB = 8;
  localparam int LW = $clog2(PB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dat_we = 0, csr_we = 0, cfg_evt = 0, irq_en = 0, in_tok = 0;
  logic tx_ready = 0, host_ack = 0, host_timeout = 0;
  logic [7:0] dat_wdata = 0, csr_wdata = 0;
  logic [7:0] csr_rdata, tx_data;
  logic irq, resp_data, resp_nak, tx_valid, tx_last, ovf;
  logic [LW-1:0] resp_len;

  always #2.5 clk = ~clk;

  bulk_in_ep #(.PKT_BYTES(PB)) uut (.*);

  int checks = 0, failures = 0;
  // reference model
  int  mcnt [2];
  bit  mcom [2];
  byte mdat [2][PB];
  int  mwr, mrd;
  bit  mdone, mund, movf;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_csr();
    logic [7:0] v = 8'h00;
    v[0] = (int'(mcom[0]) + int'(mcom[1])) <= 1;
    v[1] = mdone;
    v[3] = mund;
    return v;
  endfunction

  function automatic void m_flush();
    mcom[0] = 0; mcom[1] = 0; mcnt[0] = 0; mcnt[1] = 0; mwr = 0; mrd = 0;
  endfunction

  task automatic chk_state(string req);
    chk(csr_rdata == exp_csr(), {req, " csr"}, csr_rdata, exp_csr());
    chk(irq == (mdone && irq_en), "R5 irq", irq, mdone && irq_en);
    chk(ovf == movf, "R11 ovf", ovf, movf);
  endtask

  task automatic wr_byte(byte d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0;
    if (mcom[mwr]) movf = 1;
    else begin
      mdat[mwr][mcnt[mwr]] = d;
      mcnt[mwr]++;
      if (mcnt[mwr] == PB) begin mcom[mwr] = 1; mwr ^= 1; end
    end
  endtask

  task automatic csr_wr(logic [7:0] v);
    @(negedge clk); csr_we = 1; csr_wdata = v;
    @(negedge clk); csr_we = 0;
    if (v[1]) mdone = 0;
    if (v[3]) mund = 0;
    if (v[2]) m_flush();
    else if (v[4] && !mcom[mwr]) begin mcom[mwr] = 1; mwr ^= 1; end
  endtask

  task automatic cfg_pulse();
    @(negedge clk); cfg_evt = 1;
    @(negedge clk); cfg_evt = 0;
    m_flush();
  endtask

  // one IN transaction; timeout selects no acknowledge
  task automatic in_xfer(bit timeout);
    bit has = mcom[mrd];
    int len = mcnt[mrd];
    @(negedge clk); in_tok = 1;
    @(negedge clk); in_tok = 0;
    if (has) begin
      chk(resp_data && !resp_nak, "R6 data answer", {resp_data, resp_nak}, 2'b10);
      chk(int'(resp_len) == len, "R2 R9 length", resp_len, len);
      for (int i = 0; i < len; ) begin
        @(negedge clk);
        tx_ready = ($urandom_range(0, 2) != 0);
        if (tx_ready) begin
          chk(tx_valid && tx_data == mdat[mrd][i] && tx_last == (i == len - 1),
              "R12 R9 R10 stream", {tx_valid, tx_last, tx_data},
              {1'b1, i == len - 1, mdat[mrd][i]});
          i++;
        end
      end
      @(negedge clk); tx_ready = 0;
      chk(!tx_valid, "R12 no extra byte", tx_valid, 0);
      if (timeout) host_timeout = 1; else host_ack = 1;
      @(negedge clk); host_timeout = 0; host_ack = 0;
      if (!timeout) begin
        mcom[mrd] = 0; mcnt[mrd] = 0; mrd ^= 1; mdone = 1;
      end
    end else begin
      chk(resp_nak && !resp_data, "R6 R8 nak", {resp_data, resp_nak}, 2'b01);
      if (!mdone) mund = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_flush(); mdone = 0; mund = 0; movf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(csr_rdata == 8'h01 && !irq && !ovf && !tx_valid && !resp_data && !resp_nak,
        "R3 reset state", csr_rdata, 8'h01);

    // R8: token on empty FIFO with done clear
    in_xfer(0); chk_state("R8");
    csr_wr(8'h08); chk_state("R8 clear");
    // R1 R3: fill both buffers, then overflow R11
    for (int i = 0; i < PB; i++) wr_byte(byte'(8'h10 + i));
    chk_state("R1");
    for (int i = 0; i < PB; i++) wr_byte(byte'(8'h40 + i));
    chk_state("R3 both full");
    wr_byte(8'hEE); chk_state("R11");
    // R10: timeout then resend; R9 order
    in_xfer(1); chk_state("R10");
    in_xfer(1);
    irq_en = 1;
    in_xfer(0); chk_state("R4 R5");
    // R6: done set, next buffer still sent
    in_xfer(0); chk_state("R6");
    // R6 R8: done set and empty: NAK without underrun
    in_xfer(0); chk_state("R8 no und");
    csr_wr(8'h02); chk_state("R4 clear");
    // R2: zero-length packet
    csr_wr(8'h10); chk_state("R2");
    in_xfer(0); chk_state("R2 zlp");
    // R2 short commit with data, then R7 flush discards
    wr_byte(8'h77); wr_byte(8'h78); csr_wr(8'h10);
    wr_byte(8'h79);
    csr_wr(8'h04); chk_state("R7 flush");
    in_xfer(0); chk_state("R7 empty after flush");
    wr_byte(8'h55); csr_wr(8'h10); cfg_pulse(); chk_state("R7 cfg");
    in_xfer(0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 19);
      @(negedge clk); irq_en = $urandom_range(0, 1);
      if (op < 10)       wr_byte(byte'($urandom));
      else if (op < 12)  csr_wr(8'h10);
      else if (op < 16)  in_xfer($urandom_range(0, 3) == 0);
      else if (op < 18)  csr_wr({4'h0, $urandom_range(0, 1) == 1, 1'b0,
                                 $urandom_range(0, 1) == 1, 1'b0});
      else if (op == 18) csr_wr(8'h04);
      else               cfg_pulse();
      chk_state("R3 R4 R5 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule